// File: doc/BRIEF.md
# Command Thread Control Register Block

This block holds the control and status registers for a set of execution threads in a command-queue engine, plus the engine-wide interrupt summary word. Software reaches it over a simple memory-mapped bus with a write strobe and a combinational read path. Each thread owns a window of registers starting at 0x100 + 0x80 × thread index. The block drives control outputs to an execution core for each thread: run, pause request, program counter, end address, priority and a fetch-flush pulse. It takes back the status the core reports: paused, waiting on an event, program-counter advance and interrupt causes.

A thread is started by loading its addresses and setting its enable bit. It can be paused and resumed through its suspend register. Software confirms the pause through the status register. A self-timed warm reset returns a thread's control state to zero. Interrupt causes are gathered per thread. Software clears them by writing zeros to the bits it wants cleared. The engine-wide summary shows each thread's pending state, and a shared interrupt line is active low.

Top module: `cqt_regfile`

## Requirements
- R1: Thread i's window starts at 0x100 + 0x80·i. Inside it the offsets are: 0x00 reset, 0x04 enable, 0x08 suspend, 0x0C status, 0x10 interrupt status, 0x14 interrupt enable, 0x20 current address, 0x24 end address, 0x30 wait, 0x40 priority. The global summary sits at 0x010. Any other offset, and any window whose index is at or above NUM_THR, reads zero and ignores writes. The summary word also ignores writes.
- R2: Writing 1 to bit 0 at offset 0x00 starts a warm reset. That bit then reads 1 for exactly RST_CYCLES cycles before it clears by itself. The rst_busy output follows the same bit.
- R3: A warm reset sets current address, end address, priority, interrupt enable, suspend and enable to zero. Bus writes and core address updates to these registers are ignored while the reset is in progress.
- R4: Bit 0 at offset 0x04 is the enable bit. The thread's run output is high when enable is 1 and no warm reset is in progress.
- R5: Writing 1 to bit 0 at offset 0x08 raises the pause-request output, and writing 0 lowers it. Bit 1 at offset 0x0C reads the core's paused input.
- R6: Interrupt status bit 0 means done, and bits 1 and 4 are error causes. Only the bits in mask 0x13 are stored; bits 2 and 3 read zero. Core pulses set bits. A bus write clears exactly the stored bits that are 0 in the written data. A set in the same cycle as a clear wins.
- R7: Any bus write to offset 0x20 loads the program counter and produces a one-cycle flush pulse in the next cycle, even when the value does not change. A core address update loads the counter without a flush pulse.
- R8: Bit i of the summary word at 0x010 reads 0 when thread i has a bit set in both interrupt status and interrupt enable. Otherwise it reads 1. Bits at or above NUM_THR read 0. irq_n is low exactly when some thread is pending.
- R9: Bit 31 at offset 0x30 reads the core's waiting input. All other bits of that register read 0.
- R10: Offset 0x24 holds a 32-bit end address. Offset 0x40 holds a PRIO_W-bit priority, and wider write data is truncated. Both can be read back, and both drive their outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from bus_addr) |
| core_paused | input | NUM_THR | Thread has actually paused |
| core_waiting | input | NUM_THR | Thread blocked on an event |
| core_pc_we | input | NUM_THR | Core advances the program counter |
| core_pc | input | NUM_THR×32 | New program counter from the core |
| core_irq_set | input | NUM_THR×5 | Interrupt cause pulses |
| thr_run | output | NUM_THR | Thread allowed to execute |
| thr_pause_req | output | NUM_THR | Pause requested |
| thr_flush | output | NUM_THR | Discard fetched commands |
| thr_rst_busy | output | NUM_THR | Warm reset in progress |
| thr_pc | output | NUM_THR×32 | Program counter |
| thr_end | output | NUM_THR×32 | End address |
| thr_prio | output | NUM_THR×PRIO_W | Priority |
| irq_n | output | 1 | Shared interrupt, active low |

## Verification
The bench builds the block with NUM_THR = 3, RST_CYCLES = 5 and PRIO_W = 3. With three threads the window at 0x280 maps to no thread, and bit 3 of the summary word is unused, so the bench can observe both as unmapped. The short reset length lets the bench count the whole busy window cycle by cycle. It also lets the bench issue several writes while a warm reset is still in progress. A 3-bit priority shows the truncation of a wide write.

// File: rtl/cqt_pkg.sv
package cqt_pkg;

    localparam int DATA_W       = 32;
    localparam int IRQ_W        = 5;
    localparam int OFF_W        = 7;
    localparam int THR_BASE     = 256;
    localparam int THR_STRIDE_LG = 7;
    localparam int GLB_SUM_ADDR = 16;

    // per-thread register offsets (the execution core and software agree on these)
    localparam logic [OFF_W-1:0] OFF_WRST  = 7'h00;
    localparam logic [OFF_W-1:0] OFF_EN    = 7'h04;
    localparam logic [OFF_W-1:0] OFF_SUSP  = 7'h08;
    localparam logic [OFF_W-1:0] OFF_STAT  = 7'h0C;
    localparam logic [OFF_W-1:0] OFF_IRQST = 7'h10;
    localparam logic [OFF_W-1:0] OFF_IRQEN = 7'h14;
    localparam logic [OFF_W-1:0] OFF_CUR   = 7'h20;
    localparam logic [OFF_W-1:0] OFF_END   = 7'h24;
    localparam logic [OFF_W-1:0] OFF_WAIT  = 7'h30;
    localparam logic [OFF_W-1:0] OFF_PRIO  = 7'h40;

    // interrupt cause bits: bit0 done, bits 1 and 4 error
    localparam logic [IRQ_W-1:0] IRQ_DONE  = 5'h01;
    localparam logic [IRQ_W-1:0] IRQ_ERR   = 5'h12;
    localparam logic [IRQ_W-1:0] IRQ_VALID = IRQ_DONE | IRQ_ERR;

    typedef struct packed {
        logic              en;
        logic              susp;
        logic [DATA_W-1:0] cur;
        logic [DATA_W-1:0] endp;
        logic [IRQ_W-1:0]  irq_en;
    } thr_ctrl_t;

    // write-zero-to-clear with hardware set taking precedence
    function automatic logic [IRQ_W-1:0] irq_next(
        input logic [IRQ_W-1:0] cur,
        input logic             clr_wr,
        input logic [IRQ_W-1:0] wdata,
        input logic [IRQ_W-1:0] set
    );
        logic [IRQ_W-1:0] kept;
        kept = clr_wr ? (cur & wdata) : cur;
        return (kept | set) & IRQ_VALID;
    endfunction

endpackage

// File: rtl/cqt_addr_dec.sv
module cqt_addr_dec
    import cqt_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int NUM_THR = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_THR-1:0] thr_sel,
    output logic               glb_sel,
    output logic [OFF_W-1:0]   off
);
    logic              in_thr;
    logic [ADDR_W-1:0] idx_full;

    assign in_thr   = addr >= ADDR_W'(THR_BASE);
    assign idx_full = (addr - ADDR_W'(THR_BASE)) >> THR_STRIDE_LG;
    assign off      = addr[OFF_W-1:0];
    assign glb_sel  = addr == ADDR_W'(GLB_SUM_ADDR);

    for (genvar i = 0; i < NUM_THR; i++) begin : g_sel
        assign thr_sel[i] = in_thr && (idx_full == ADDR_W'(i));
    end

endmodule

// File: rtl/cqt_thread.sv
module cqt_thread
    import cqt_pkg::*;
#(
    parameter int PRIO_W     = 3,
    parameter int RST_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              core_paused,
    input  logic              core_waiting,
    input  logic              core_pc_we,
    input  logic [DATA_W-1:0] core_pc,
    input  logic [IRQ_W-1:0]  core_irq_set,
    output logic              run,
    output logic              pause_req,
    output logic              flush,
    output logic              rst_busy,
    output logic [DATA_W-1:0] pc,
    output logic [DATA_W-1:0] end_addr,
    output logic [PRIO_W-1:0] prio,
    output logic              pend
);
    localparam int CNT_W = $clog2(RST_CYCLES + 1);

    thr_ctrl_t         ctrl_q;
    logic [PRIO_W-1:0] prio_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              flush_q;
    logic [IRQ_W-1:0]  irq_q;
    logic              busy;

    assign busy = cnt_q != '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            prio_q  <= '0;
            cnt_q   <= '0;
            flush_q <= 1'b0;
        end else begin
            flush_q <= 1'b0;
            if (busy) begin
                ctrl_q <= '0;
                prio_q <= '0;
                cnt_q  <= cnt_q - 1'b1;
            end else begin
                if (core_pc_we) ctrl_q.cur <= core_pc;
                if (wr_en) begin
                    case (off)
                        OFF_WRST: if (wdata[0]) begin
                            ctrl_q <= '0;
                            prio_q <= '0;
                            cnt_q  <= CNT_W'(RST_CYCLES);
                        end
                        OFF_EN:    ctrl_q.en     <= wdata[0];
                        OFF_SUSP:  ctrl_q.susp   <= wdata[0];
                        OFF_IRQEN: ctrl_q.irq_en <= wdata[IRQ_W-1:0] & IRQ_VALID;
                        OFF_CUR: begin
                            ctrl_q.cur <= wdata;
                            flush_q    <= 1'b1;
                        end
                        OFF_END:   ctrl_q.endp   <= wdata;
                        OFF_PRIO:  prio_q        <= wdata[PRIO_W-1:0];
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= '0;
        else     irq_q <= irq_next(irq_q, wr_en && (off == OFF_IRQST),
                                   wdata[IRQ_W-1:0], core_irq_set);
    end

    always_comb begin
        rdata = '0;
        case (off)
            OFF_WRST:  rdata[0]          = busy;
            OFF_EN:    rdata[0]          = ctrl_q.en;
            OFF_SUSP:  rdata[0]          = ctrl_q.susp;
            OFF_STAT:  rdata[1]          = core_paused;
            OFF_IRQST: rdata[IRQ_W-1:0]  = irq_q;
            OFF_IRQEN: rdata[IRQ_W-1:0]  = ctrl_q.irq_en;
            OFF_CUR:   rdata             = ctrl_q.cur;
            OFF_END:   rdata             = ctrl_q.endp;
            OFF_WAIT:  rdata[DATA_W-1]   = core_waiting;
            OFF_PRIO:  rdata[PRIO_W-1:0] = prio_q;
            default: ;
        endcase
    end

    assign run       = ctrl_q.en && !busy;
    assign pause_req = ctrl_q.susp;
    assign flush     = flush_q;
    assign rst_busy  = busy;
    assign pc        = ctrl_q.cur;
    assign end_addr  = ctrl_q.endp;
    assign prio      = prio_q;
    assign pend      = |(irq_q & ctrl_q.irq_en);

    assert_rst_count_R2: assert property (@(posedge clk) disable iff (rst)
        busy |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));

    assert_rst_clear_R3: assert property (@(posedge clk) disable iff (rst)
        busy |=> (ctrl_q == '0 && prio_q == '0));

    assert_irq_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && off == OFF_IRQST && core_irq_set == '0)
        |=> (irq_q == ($past(irq_q) & $past(wdata[IRQ_W-1:0]))));

    assert_flush_load_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && off == OFF_CUR && !busy) |=> (flush && pc == $past(wdata)));

endmodule

// File: rtl/cqt_irq_sum.sv
module cqt_irq_sum
    import cqt_pkg::*;
#(
    parameter int NUM_THR = 4
) (
    input  logic [NUM_THR-1:0] pend,
    output logic [DATA_W-1:0]  sum_word,
    output logic               irq_n
);
    localparam int PAD_W = DATA_W - NUM_THR;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i < NUM_THR) begin : g_thr
            assign sum_word[i] = !pend[i];
        end else begin : g_pad
            assign sum_word[i] = 1'b0;
        end
    end

    assign irq_n = &sum_word[NUM_THR-1:0];

    initial begin
        assert_width_R8: assert (PAD_W >= 0);
    end

endmodule

// File: rtl/cqt_regfile.sv
module cqt_regfile
    import cqt_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int NUM_THR    = 4,
    parameter int PRIO_W     = 3,
    parameter int RST_CYCLES = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    input  logic [NUM_THR-1:0]          core_paused,
    input  logic [NUM_THR-1:0]          core_waiting,
    input  logic [NUM_THR-1:0]          core_pc_we,
    input  logic [NUM_THR*DATA_W-1:0]   core_pc,
    input  logic [NUM_THR*IRQ_W-1:0]    core_irq_set,
    output logic [NUM_THR-1:0]          thr_run,
    output logic [NUM_THR-1:0]          thr_pause_req,
    output logic [NUM_THR-1:0]          thr_flush,
    output logic [NUM_THR-1:0]          thr_rst_busy,
    output logic [NUM_THR*DATA_W-1:0]   thr_pc,
    output logic [NUM_THR*DATA_W-1:0]   thr_end,
    output logic [NUM_THR*PRIO_W-1:0]   thr_prio,
    output logic                        irq_n
);
    logic [NUM_THR-1:0] thr_sel;
    logic               glb_sel;
    logic [OFF_W-1:0]   off;
    logic [NUM_THR-1:0] pend;
    logic [DATA_W-1:0]  sum_word;
    logic [DATA_W-1:0]  thr_rdata [NUM_THR];

    cqt_addr_dec #(.ADDR_W(ADDR_W), .NUM_THR(NUM_THR)) u_dec (
        .addr    (bus_addr),
        .thr_sel (thr_sel),
        .glb_sel (glb_sel),
        .off     (off)
    );

    for (genvar i = 0; i < NUM_THR; i++) begin : g_thr
        cqt_thread #(.PRIO_W(PRIO_W), .RST_CYCLES(RST_CYCLES)) u_thr (
            .clk          (clk),
            .rst          (rst),
            .wr_en        (bus_wr && thr_sel[i]),
            .off          (off),
            .wdata        (bus_wdata),
            .rdata        (thr_rdata[i]),
            .core_paused  (core_paused[i]),
            .core_waiting (core_waiting[i]),
            .core_pc_we   (core_pc_we[i]),
            .core_pc      (core_pc[i*DATA_W +: DATA_W]),
            .core_irq_set (core_irq_set[i*IRQ_W +: IRQ_W]),
            .run          (thr_run[i]),
            .pause_req    (thr_pause_req[i]),
            .flush        (thr_flush[i]),
            .rst_busy     (thr_rst_busy[i]),
            .pc           (thr_pc[i*DATA_W +: DATA_W]),
            .end_addr     (thr_end[i*DATA_W +: DATA_W]),
            .prio         (thr_prio[i*PRIO_W +: PRIO_W]),
            .pend         (pend[i])
        );
    end

    cqt_irq_sum #(.NUM_THR(NUM_THR)) u_sum (
        .pend     (pend),
        .sum_word (sum_word),
        .irq_n    (irq_n)
    );

    always_comb begin
        bus_rdata = glb_sel ? sum_word : '0;
        for (int i = 0; i < NUM_THR; i++) begin
            if (thr_sel[i]) bus_rdata = bus_rdata | thr_rdata[i];
        end
    end

    assert_one_window_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({thr_sel, glb_sel}));

    assert_line_matches_R8: assert property (@(posedge clk) disable iff (rst)
        irq_n == !(|pend));

endmodule

// File: tb/cqt_regfile_tb.sv
module cqt_regfile_tb;
    localparam int NT = 3;
    localparam int RC = 5;
    localparam int PW = 3;
    localparam int AW = 12;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NT-1:0]     core_paused = '0;
    logic [NT-1:0]     core_waiting = '0;
    logic [NT-1:0]     core_pc_we = '0;
    logic [NT*32-1:0]  core_pc = '0;
    logic [NT*5-1:0]   core_irq_set = '0;
    logic [NT-1:0]     thr_run, thr_pause_req, thr_flush, thr_rst_busy;
    logic [NT*32-1:0]  thr_pc, thr_end;
    logic [NT*PW-1:0]  thr_prio;
    logic              irq_n;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cqt_regfile #(.ADDR_W(AW), .NUM_THR(NT), .PRIO_W(PW), .RST_CYCLES(RC)) u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_paused(core_paused), .core_waiting(core_waiting),
        .core_pc_we(core_pc_we), .core_pc(core_pc), .core_irq_set(core_irq_set),
        .thr_run(thr_run), .thr_pause_req(thr_pause_req), .thr_flush(thr_flush),
        .thr_rst_busy(thr_rst_busy), .thr_pc(thr_pc), .thr_end(thr_end),
        .thr_prio(thr_prio), .irq_n(irq_n)
    );

    function automatic logic [AW-1:0] ta(input int t, input int o);
        return AW'(256 + t * 128 + o);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bwrite(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [AW-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic irq_pulse(input int t, input logic [4:0] v);
        @(negedge clk);
        core_irq_set[t*5 +: 5] = v;
        @(negedge clk);
        core_irq_set[t*5 +: 5] = '0;
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        bread(ta(0, 'h04), d); chk("R4 enable after reset", d, 0);
        bread(ta(0, 'h00), d); chk("R2 reset bit idle", d, 0);
        bread(AW'(16), d);     chk("R8 summary after reset", d, 32'h7);
        chk("R8 irq_n after reset", 32'(irq_n), 1);
        chk("R4 run after reset", 32'(thr_run), 0);
    endtask

    task automatic t_window_R1();
        logic [31:0] d;
        bwrite(ta(0, 'h20), 32'h1111_0000);
        bwrite(ta(2, 'h20), 32'h2222_0000);
        bread(ta(0, 'h20), d); chk("R1 thread0 window", d, 32'h1111_0000);
        bread(ta(2, 'h20), d); chk("R1 thread2 window", d, 32'h2222_0000);
        chk("R1 thread1 untouched", thr_pc[32 +: 32], 0);
        bwrite(ta(3, 'h20), 32'hFFFF_FFFF);
        bread(ta(3, 'h20), d); chk("R1 missing thread reads 0", d, 0);
        bwrite(ta(0, 'h18), 32'hFFFF_FFFF);
        bread(ta(0, 'h18), d); chk("R1 unmapped offset reads 0", d, 0);
        bread(ta(0, 'h20), d); chk("R1 unmapped write ignored", d, 32'h1111_0000);
        bwrite(AW'(16), 32'h0);
        bread(AW'(16), d); chk("R1 summary write ignored", d, 32'h7);
    endtask

    task automatic t_enable_R4();
        logic [31:0] d;
        bwrite(ta(0, 'h04), 32'h1);
        bread(ta(0, 'h04), d); chk("R4 enable readback", d, 1);
        chk("R4 run high", 32'(thr_run), 32'h1);
        bwrite(ta(0, 'h04), 32'h0);
        chk("R4 run low", 32'(thr_run), 0);
    endtask

    task automatic t_suspend_R5();
        logic [31:0] d;
        bwrite(ta(0, 'h08), 32'h1);
        chk("R5 pause request", 32'(thr_pause_req), 32'h1);
        bread(ta(0, 'h0C), d); chk("R5 not yet paused", d, 0);
        core_paused[0] = 1'b1;
        bread(ta(0, 'h0C), d); chk("R5 paused status", d, 32'h2);
        bwrite(ta(0, 'h08), 32'h0);
        chk("R5 resume", 32'(thr_pause_req), 0);
        core_paused[0] = 1'b0;
    endtask

    task automatic t_endprio_R10();
        logic [31:0] d;
        bwrite(ta(2, 'h24), 32'hDEAD_BEEF);
        bwrite(ta(2, 'h40), 32'hFF);
        bread(ta(2, 'h24), d); chk("R10 end readback", d, 32'hDEAD_BEEF);
        bread(ta(2, 'h40), d); chk("R10 priority truncated", d, 32'h7);
        chk("R10 end output", thr_end[64 +: 32], 32'hDEAD_BEEF);
        chk("R10 priority output", 32'(thr_prio[6 +: 3]), 32'h7);
    endtask

    task automatic t_wait_R9();
        logic [31:0] d;
        core_waiting[2] = 1'b1;
        bread(ta(2, 'h30), d); chk("R9 waiting", d, 32'h8000_0000);
        core_waiting[2] = 1'b0;
        bread(ta(2, 'h30), d); chk("R9 not waiting", d, 0);
    endtask

    task automatic t_flush_R7();
        logic [31:0] d;
        bwrite(ta(1, 'h20), 32'h0000_4000);
        chk("R7 flush pulse", 32'(thr_flush), 32'h2);
        chk("R7 pc output", thr_pc[32 +: 32], 32'h0000_4000);
        @(negedge clk);
        chk("R7 flush one cycle", 32'(thr_flush), 0);
        bwrite(ta(1, 'h20), 32'h0000_4000);
        chk("R7 flush on same value", 32'(thr_flush), 32'h2);
        @(negedge clk);
        core_pc_we[1] = 1'b1; core_pc[32 +: 32] = 32'h0000_4040;
        @(negedge clk);
        core_pc_we[1] = 1'b0;
        chk("R7 no flush on core update", 32'(thr_flush), 0);
        bread(ta(1, 'h20), d); chk("R7 core update loads pc", d, 32'h0000_4040);
    endtask

    task automatic t_irq_R6_R8();
        logic [31:0] d;
        irq_pulse(1, 5'h01);
        bread(ta(1, 'h10), d); chk("R6 done bit set", d, 32'h01);
        bread(AW'(16), d); chk("R8 not pending when disabled", d, 32'h7);
        chk("R8 irq_n idle", 32'(irq_n), 1);
        bwrite(ta(1, 'h14), 32'hFF);
        bread(ta(1, 'h14), d); chk("R6 enable masked to 0x13", d, 32'h13);
        bread(AW'(16), d); chk("R8 thread1 pending", d, 32'h5);
        chk("R8 irq_n asserted", 32'(irq_n), 0);
        irq_pulse(1, 5'h1C);
        bread(ta(1, 'h10), d); chk("R6 error bit, bits 2-3 dropped", d, 32'h11);
        bwrite(ta(1, 'h10), 32'h10);
        bread(ta(1, 'h10), d); chk("R6 zero bit cleared only", d, 32'h10);
        bwrite(ta(1, 'h10), 32'h0);
        bread(ta(1, 'h10), d); chk("R6 all cleared", d, 0);
        bread(AW'(16), d); chk("R8 summary idle again", d, 32'h7);
        chk("R8 irq_n released", 32'(irq_n), 1);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = ta(1, 'h10); bus_wdata = 32'h0;
        core_irq_set[5 +: 5] = 5'h02;
        @(negedge clk);
        bus_wr = 1'b0; core_irq_set[5 +: 5] = '0;
        bread(ta(1, 'h10), d); chk("R6 set wins over clear", d, 32'h02);
        bwrite(ta(1, 'h10), 32'h0);
    endtask

    task automatic t_warm_R2_R3();
        logic [31:0] d;
        int n;
        bwrite(ta(0, 'h04), 32'h1);
        bwrite(ta(0, 'h08), 32'h1);
        bwrite(ta(0, 'h20), 32'hC0DE_0000);
        bwrite(ta(0, 'h24), 32'hC0DE_1000);
        bwrite(ta(0, 'h40), 32'h3);
        bwrite(ta(0, 'h14), 32'h13);
        bwrite(ta(0, 'h00), 32'h1);
        chk("R2 busy output", 32'(thr_rst_busy), 32'h1);
        chk("R4 run low during reset", 32'(thr_run), 0);
        n = 0;
        bread(ta(0, 'h00), d);
        while (d[0] && n < 50) begin
            n++;
            @(negedge clk);
            bread(ta(0, 'h00), d);
        end
        chk("R2 busy length", 32'(n), 32'(RC));
        bread(ta(0, 'h04), d); chk("R3 enable cleared", d, 0);
        bread(ta(0, 'h08), d); chk("R3 suspend cleared", d, 0);
        bread(ta(0, 'h20), d); chk("R3 current cleared", d, 0);
        bread(ta(0, 'h24), d); chk("R3 end cleared", d, 0);
        bread(ta(0, 'h40), d); chk("R3 priority cleared", d, 0);
        bread(ta(0, 'h14), d); chk("R3 irq enable cleared", d, 0);
    endtask

    task automatic t_busy_ignore_R3();
        logic [31:0] d;
        int n;
        bwrite(ta(0, 'h00), 32'h1);
        bwrite(ta(0, 'h04), 32'h1);
        bwrite(ta(0, 'h24), 32'h0000_0123);
        n = 0;
        bread(ta(0, 'h00), d);
        while (d[0] && n < 50) begin
            n++;
            @(negedge clk);
            bread(ta(0, 'h00), d);
        end
        bread(ta(0, 'h04), d); chk("R3 enable write ignored while busy", d, 0);
        bread(ta(0, 'h24), d); chk("R3 end write ignored while busy", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_window_R1();
        t_enable_R4();
        t_suspend_R5();
        t_endprio_R10();
        t_wait_R9();
        t_flush_R7();
        t_irq_R6_R8();
        t_warm_R2_R3();
        t_busy_ignore_R3();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule